// File: doc/BRIEF.md
# Multi-Mode Configuration Register Loader

After each reset this block fills an 18-bit configuration register from one of three sources. A two-bit strap code, sampled as reset is released, picks the source. In auxiliary mode, bits arrive on a data pin and are clocked in by an external, free-running clock pin. In preset mode, one of eight fixed words is copied from an internal constant table. In serial-memory mode, bits arrive from a separate serial memory reader through a bit/valid handshake.

The selected source is kept until the next reset. While loading is in progress the configuration output reads all zeros. Once loading finishes, a done flag rises and the word stays frozen. One preset is reserved for test: when it is chosen, a PLL-bypass output is raised so that low-frequency testing can proceed.

Top module: `cfg_loader`

## Requirements
- R1: The configuration word is 18 bits wide. `cfg_word` reads all zeros whenever `cfg_done` is low.
- R2: The source is sampled on the first rising edge of `clk` with `rst_n` high. `strap_mode` 2'b01 selects auxiliary mode, 2'b00 selects preset mode, and 2'b10 or 2'b11 (strap floating) selects serial-memory mode.
- R3: In auxiliary mode, each rising edge of `ext_clk` (seen through a two-flop synchroniser) shifts in `ext_data`. Bits enter MSB first, so the first bit ends in bit 17. `cfg_done` rises together with the 18th bit.
- R4: In auxiliary mode, `ext_clk` edges after the 18th leave `cfg_word` unchanged.
- R5: In preset mode, the code {`rom_msb`, `ext_clk`, `ext_data`} (rom_msb is the MSB) is sampled on the same edge as the strap. The loaded word is that 3-bit code repeated six times, with the code itself in bits 2:0.
- R6: In preset mode, `cfg_done` is low one cycle after the sampling edge and high after the second edge that follows it.
- R7: `pll_bypass` is high only when preset mode is in use, the code is 7 and loading is done. In every other case it stays low.
- R8: In serial-memory mode, each cycle with `ee_valid` high shifts in `ee_bit`, MSB first. `cfg_done` rises with the 18th bit. Later valid pulses and all `ext_clk` edges have no effect.
- R9: `cfg_done` stays high until the next reset. A synchronous low `rst_n` clears `cfg_word`, `cfg_done` and `pll_bypass`.
- R10: Changes on the strap and code pins after the sampling edge change neither the source nor the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mode | input | 2 | Encoded source strap: 00 low, 01 high, 1x floating |
| rom_msb | input | 1 | MSB of the preset code |
| ext_clk | input | 1 | Auxiliary shift clock; middle bit of the preset code |
| ext_data | input | 1 | Auxiliary data; LSB of the preset code |
| ee_bit | input | 1 | Serial-memory reader data bit |
| ee_valid | input | 1 | Serial-memory reader bit strobe |
| cfg_word | output | 18 | Configuration word; zero until done |
| cfg_done | output | 1 | Loading finished |
| pll_bypass | output | 1 | Test preset selected |

## Verification
The bench runs all eight preset codes from a table. A wrong code bit order or a wrong table entry would show up as a mismatched word, and a missing copy-to-done delay would raise done one cycle early. In the shifting modes it checks the word after 17 bits and after 18 bits. A counter that is off by one would either finish early and expose a partial word, or finish late. Extra clock edges and valid pulses are sent after completion and must leave the word frozen. Activity from the source that was not selected is also sent, and must not leak into the word, so a design that decodes the strap wrongly or fails to hold the latched source would load the wrong bits.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the configuration loader.
package cfg_loader_pkg;
    // Load source latched at reset release.
    typedef enum logic [1:0] {
        SRC_ROM  = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_MAIN = 2'd2
    } src_e;
endpackage

// File: rtl/cfg_edge_sync.sv
// Brings an asynchronous clock pin and its data pin into the clk domain.
// It pulses rise for one cycle per rising edge of the pin clock.
// Assumes: the pin clock stays at each level for at least STAGES+1 system cycles.
module cfg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk,
    input  logic pin_data,
    output logic rise,
    output logic data_s
);
    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_last;

    // Synchroniser chains for clock and data, plus the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sh   <= '0;
            dat_sh   <= '0;
            clk_last <= 1'b0;
        end else begin
            clk_sh   <= {clk_sh[STAGES-2:0], pin_clk};
            dat_sh   <= {dat_sh[STAGES-2:0], pin_data};
            clk_last <= clk_sh[STAGES-1];
        end
    end

    // The edge and the data come from the same synchroniser depth, so they stay aligned.
    always_comb begin
        rise   = clk_sh[STAGES-1] & ~clk_last;
        data_s = dat_sh[STAGES-1];
    end
endmodule

// File: rtl/cfg_preset_rom.sv
// Constant table of preset configuration words. Entry i holds the code i
// repeated across the word, and its top bit is the test flag, which is set
// only in the last entry.
// Assumes: code is stable while it is read.
module cfg_preset_rom #(
    parameter int CODE_W = 3,
    parameter int CFG_W  = 18
) (
    input  logic [CODE_W-1:0] code,
    output logic [CFG_W-1:0]  word,
    output logic              test
);
    localparam int NUM = 1 << CODE_W;

    function automatic logic [CFG_W-1:0] fill(input logic [CODE_W-1:0] c);
        logic [CFG_W-1:0] w;
        for (int b = 0; b < CFG_W; b++) w[b] = c[b % CODE_W];
        return w;
    endfunction

    logic [CFG_W:0] table_q [NUM];

    // Each table entry is computed from its index.
    for (genvar g = 0; g < NUM; g++) begin : g_entry
        localparam logic [CODE_W-1:0] IDX = CODE_W'(g);
        assign table_q[g] = {(g == NUM - 1), fill(IDX)};
    end

    // Table read.
    always_comb begin
        word = table_q[code][CFG_W-1:0];
        test = table_q[code][CFG_W];
    end
endmodule

// File: rtl/cfg_shifter.sv
// The shared configuration register. It is filled either by a parallel load
// (done follows one cycle later) or by CFG_W serial shifts, MSB first.
// Once done it freezes until reset.
// Assumes: load and shift_en are never high in the same cycle.
module cfg_shifter #(
    parameter int CFG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] load_word,
    input  logic             shift_en,
    input  logic             shift_bit,
    output logic [CFG_W-1:0] word,
    output logic             done
);
    localparam int CNT_W = $clog2(CFG_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             loaded_q;

    // Register fill, shift count and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word     <= '0;
            cnt_q    <= '0;
            loaded_q <= 1'b0;
            done     <= 1'b0;
        end else if (done) begin
            word <= word;
        end else if (loaded_q) begin
            done <= 1'b1;
        end else if (load) begin
            word     <= load_word;
            loaded_q <= 1'b1;
        end else if (shift_en) begin
            word  <= {word[CFG_W-2:0], shift_bit};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(CFG_W - 1)) done <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_loader.sv
// Top of the configuration loader. It latches the source strap and the preset
// code on the first clock after reset, routes the chosen source into the
// shared register, and gates the outputs until loading is complete.
// Assumes: rst_n is synchronous to clk; strap_mode arrives already encoded.
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CFG_W       = 18,
    parameter int CODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap_mode,
    input  logic             rom_msb,
    input  logic             ext_clk,
    input  logic             ext_data,
    input  logic             ee_bit,
    input  logic             ee_valid,
    output logic [CFG_W-1:0] cfg_word,
    output logic             cfg_done,
    output logic             pll_bypass
);
    src_e              src_q;
    logic              started_q;
    logic [CODE_W-1:0] code_q;
    logic              aux_rise, aux_bit;
    logic [CFG_W-1:0]  rom_word, sh_word;
    logic              rom_test, sh_done;
    logic              do_load, do_shift, sh_bit;

    // Latch the source and the preset code once, on the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            src_q     <= SRC_ROM;
            code_q    <= '0;
        end else if (!started_q) begin
            started_q <= 1'b1;
            code_q    <= CODE_W'({rom_msb, ext_clk, ext_data});
            case (strap_mode)
                2'b00:   src_q <= SRC_ROM;
                2'b01:   src_q <= SRC_AUX;
                default: src_q <= SRC_MAIN;
            endcase
        end
    end

    cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_clk  (ext_clk),
        .pin_data (ext_data),
        .rise     (aux_rise),
        .data_s   (aux_bit)
    );

    cfg_preset_rom #(.CODE_W(CODE_W), .CFG_W(CFG_W)) u_rom (
        .code (code_q),
        .word (rom_word),
        .test (rom_test)
    );

    // Route the latched source to the shifter controls.
    always_comb begin
        do_load  = started_q && (src_q == SRC_ROM);
        do_shift = started_q && (((src_q == SRC_AUX) && aux_rise) ||
                                 ((src_q == SRC_MAIN) && ee_valid));
        sh_bit   = (src_q == SRC_AUX) ? aux_bit : ee_bit;
    end

    cfg_shifter #(.CFG_W(CFG_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_word (rom_word),
        .shift_en  (do_shift),
        .shift_bit (sh_bit),
        .word      (sh_word),
        .done      (sh_done)
    );

    // Outputs stay quiet until loading has finished.
    always_comb begin
        cfg_done   = sh_done;
        cfg_word   = sh_done ? sh_word : '0;
        pll_bypass = sh_done && (src_q == SRC_ROM) && rom_test;
    end
endmodule

// File: rtl/cfg_loader_chk.sv
// Temporal checks on the configuration loader, bound to its top.
module cfg_loader_chk
    import cfg_loader_pkg::*;
#(
    parameter int CFG_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_word,
    input logic             cfg_done,
    input logic             pll_bypass,
    input logic             started_q,
    input src_e             src_q
);
    AST_ZERO_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cfg_word) == '0); // R1

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> $stable(cfg_word)); // R4

    AST_BYPASS_ONLY_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (cfg_done && src_q == SRC_ROM && cfg_word == {CFG_W{1'b1}})); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done); // R9

    AST_SOURCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(started_q)) |-> $stable(src_q)); // R10
endmodule

bind cfg_loader cfg_loader_chk #(.CFG_W(CFG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg_word),
    .cfg_done   (cfg_done),
    .pll_bypass (pll_bypass),
    .started_q  (started_q),
    .src_q      (src_q)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_mode = 2'b00;
    logic        rom_msb = 1'b0, ext_clk = 1'b0, ext_data = 1'b0;
    logic        ee_bit = 1'b0, ee_valid = 1'b0;
    logic [17:0] cfg_word;
    logic        cfg_done, pll_bypass;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .rom_msb(rom_msb),
        .ext_clk(ext_clk), .ext_data(ext_data), .ee_bit(ee_bit), .ee_valid(ee_valid),
        .cfg_word(cfg_word), .cfg_done(cfg_done), .pll_bypass(pll_bypass)
    );

    // Entries: {code, expected bypass, expected word}; word = code repeated six times.
    localparam logic [21:0] VEC [8] = '{
        {3'd0, 1'b0, 18'h00000}, {3'd1, 1'b0, 18'h09249},
        {3'd2, 1'b0, 18'h12492}, {3'd3, 1'b0, 18'h1B6DB},
        {3'd4, 1'b0, 18'h24924}, {3'd5, 1'b0, 18'h2DB6D},
        {3'd6, 1'b0, 18'h36DB6}, {3'd7, 1'b1, 18'h3FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] mode, input logic [2:0] code);
        rst_n = 1'b0;
        strap_mode = mode;
        {rom_msb, ext_clk, ext_data} = code;
        ee_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic aux_edge(input logic b);
        ext_data = b;
        ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ee_send(input logic b);
        ee_bit = b;
        ee_valid = 1'b1;
        @(negedge clk);
        ee_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [17:0] pat;

        // Reset state (R9)
        repeat (3) @(negedge clk);
        chk("R9 reset word", 32'(cfg_word), 0);
        chk("R9 reset done", 32'(cfg_done), 0);
        chk("R9 reset bypass", 32'(pll_bypass), 0);

        // Preset table walk (R5, R6, R7, R10)
        for (int i = 0; i < 8; i++) begin
            start(2'b00, VEC[i][21:19]);
            @(negedge clk);
            chk("R6 done low after copy", 32'(cfg_done), 0);
            chk("R1 word zero before done", 32'(cfg_word), 0);
            @(negedge clk);
            chk("R6 done high", 32'(cfg_done), 1);
            chk("R5 preset word", 32'(cfg_word), 32'(VEC[i][17:0]));
            chk("R7 bypass", 32'(pll_bypass), 32'(VEC[i][18]));
            strap_mode = 2'b01;
            {rom_msb, ext_clk, ext_data} = ~VEC[i][21:19];
            repeat (6) @(negedge clk);
            chk("R10 word after strap change", 32'(cfg_word), 32'(VEC[i][17:0]));
        end

        // Auxiliary mode (R2, R3, R4, R8 inverse)
        pat = 18'h2B3C5;
        start(2'b01, 3'b000);
        ee_send(1'b1);
        ee_send(1'b1);
        for (int b = 17; b >= 1; b--) aux_edge(pat[b]);
        chk("R3 not done after 17 bits", 32'(cfg_done), 0);
        chk("R1 zero while loading", 32'(cfg_word), 0);
        aux_edge(pat[0]);
        chk("R3 done after 18 bits", 32'(cfg_done), 1);
        chk("R3 aux word", 32'(cfg_word), 32'(pat));
        chk("R7 no bypass in aux", 32'(pll_bypass), 0);
        for (int b = 0; b < 4; b++) aux_edge(~pat[b]);
        chk("R4 extra edges ignored", 32'(cfg_word), 32'(pat));

        // Serial-memory mode, strap 10 (R8)
        pat = 18'h15A3C;
        start(2'b10, 3'b111);
        aux_edge(1'b1);
        aux_edge(1'b1);
        for (int b = 17; b >= 1; b--) ee_send(pat[b]);
        chk("R8 not done after 17 bits", 32'(cfg_done), 0);
        ee_send(pat[0]);
        chk("R8 done after 18 bits", 32'(cfg_done), 1);
        chk("R8 memory word", 32'(cfg_word), 32'(pat));
        chk("R7 no bypass in memory mode", 32'(pll_bypass), 0);
        for (int b = 0; b < 3; b++) ee_send(~pat[b]);
        chk("R8 late pulses ignored", 32'(cfg_word), 32'(pat));

        // Strap 11 also selects serial-memory mode (R2)
        pat = 18'h3C0F1;
        start(2'b11, 3'b000);
        for (int b = 17; b >= 0; b--) ee_send(pat[b]);
        chk("R2 strap 11 selects memory", 32'(cfg_word), 32'(pat));

        // Reset clears after done (R9)
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 word cleared", 32'(cfg_word), 0);
        chk("R9 done cleared", 32'(cfg_done), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule